// File: doc/BRIEF.md
# Page Write Staging Buffer and Commit Sequencer

This block sits behind a two-wire serial memory slave engine and gathers the data bytes of one write transaction into a row-sized staging buffer. The slave engine gives it a start address, then one strobe per received data byte. When the engine sees a stop in the valid slot, it raises a commit request. The block then enters a fixed-length internal write cycle. During that cycle it replays every staged byte into a memory array through a simple write port and holds a busy flag for the whole period.

The byte cursor only advances in its low-order bits. A transfer that runs past the end of a row therefore wraps to the start of that same row and overwrites what is already staged there. A transaction that ends without a commit (abort, wrong-slot stop, repeated start) discards the staged bytes. The committed address counter is updated only when a write cycle completes. A single-byte write is a page write with one staged byte. Row size (a power of two) and write-cycle length in clocks are parameters.

Top module: `pgbuf_commit_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` is 0, `mem_we` is 0 and `addr_cnt` is 0.
- R2: Each accepted data byte is stored in the slot given by the low log2(PAGE_BYTES) bits of the cursor. A commit writes every stored slot, and only stored slots, to address {cursor row bits, slot} with the stored byte.
- R3: After each accepted byte only the low log2(PAGE_BYTES) cursor bits increment. Past the last slot of a row the cursor wraps to slot 0 of the same row, and the row bits never change.
- R4: When two bytes land in the same slot after a wrap, the later byte is the one written to memory.
- R5: An accepted commit raises `busy` at the next clock edge and keeps it high for exactly max(WCYC_CYCLES, PAGE_BYTES) clock cycles.
- R6: While `busy` is high, `addr_load`, `data_stb`, `commit_req` and `abort_req` have no effect on staged data, the cursor or `addr_cnt`.
- R7: `addr_cnt` changes only on the edge that ends a write cycle. It then takes the address following the last accepted byte, wrapped within the row.
- R8: `abort_req` discards all staged bytes and returns the cursor to `addr_cnt`. `addr_cnt` itself is left unchanged.
- R9: A commit request with no staged bytes starts no write cycle and produces no memory write. It discards the transaction the same way an abort does.
- R10: When several requests arrive in one idle cycle, only one is taken. The order of precedence is abort, then commit, then data byte, then address load.
- R11: A data byte sent with no preceding address load in the transaction is stored at `addr_cnt`.
- R12: Memory writes occur only while `busy` is high, one per clock, within the first PAGE_BYTES cycles of the write cycle, in strictly ascending slot order and all within one row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the cursor with `load_addr` |
| load_addr | input | ADDR_W | Start address of the transaction |
| data_stb | input | 1 | One data byte present on `data_in` |
| data_in | input | 8 | Data byte |
| commit_req | input | 1 | Valid stop seen: start the write cycle |
| abort_req | input | 1 | Transaction ended without a commit: discard |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Memory array write strobe |
| mem_addr | output | ADDR_W | Memory array write address (0 when idle) |
| mem_wdata | output | 8 | Memory array write data (0 when idle) |
| addr_cnt | output | ADDR_W | Committed address counter |

## Verification
A stale or wrongly set valid bit shows up as an extra or missing `mem_we` pulse in the first PAGE_BYTES cycles of the next write cycle. A bad cursor shows as a wrong `mem_addr` in that same cycle. It also shows as a wrong `addr_cnt` on the edge that ends the cycle, so such faults appear at most one write cycle after the faulty byte. A timer fault is visible at once as `busy` falling one cycle early or late. Requests that leak through while busy are visible no later than the end of the following commit, as memory contents or counter values that differ from the reference.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_LOAD,
    EV_BYTE,
    EV_COMMIT,
    EV_CLEAR
  } pg_ev_e;

  // Write-cycle length: never shorter than one scan of the whole row.
  function automatic int unsigned busy_len(input int unsigned wcyc, input int unsigned page);
    return (wcyc > page) ? wcyc : page;
  endfunction

endpackage

// File: rtl/pgbuf_evsel.sv
module pgbuf_evsel
  import pgbuf_pkg::*;
(
  input  logic   busy,
  input  logic   abort_req,
  input  logic   commit_req,
  input  logic   data_stb,
  input  logic   addr_load,
  input  logic   any_valid,
  output pg_ev_e ev
);
  // One event per idle cycle; abort > commit > byte > load.
  always_comb begin
    ev = EV_NONE;
    if (!busy) begin
      if (abort_req)       ev = EV_CLEAR;
      else if (commit_req) ev = any_valid ? EV_COMMIT : EV_CLEAR;
      else if (data_stb)   ev = EV_BYTE;
      else if (addr_load)  ev = EV_LOAD;
    end
  end
endmodule

// File: rtl/pgbuf_stage.sv
module pgbuf_stage #(
  parameter int PAGE_BYTES = 128,
  localparam int PAW = $clog2(PAGE_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [PAW-1:0] wr_slot,
  input  logic [7:0]     wr_data,
  input  logic           clr,
  input  logic [PAW-1:0] rd_slot,
  output logic [7:0]     rd_data,
  output logic           rd_valid,
  output logic           any_valid
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == PAW'(g))) slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (clr)   valid_q <= '0;
    else if (wr_en) valid_q[wr_slot] <= 1'b1;
  end

  assign rd_data   = slot_q[rd_slot];
  assign rd_valid  = valid_q[rd_slot];
  assign any_valid = |valid_q;
endmodule

// File: rtl/pgbuf_cursor.sv
module pgbuf_cursor #(
  parameter int ADDR_W = 16,
  parameter int PAW    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_load,
  input  logic              ev_byte,
  input  logic              ev_clear,
  input  logic              ev_done,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] wp,
  output logic [ADDR_W-1:0] addr_cnt
);
  // Advance within the row: low bits wrap, row bits held.
  function automatic logic [ADDR_W-1:0] row_next(input logic [ADDR_W-1:0] a);
    logic [PAW-1:0] lo;
    lo = a[PAW-1:0] + 1'b1;
    return {a[ADDR_W-1:PAW], lo};
  endfunction

  logic [ADDR_W-1:0] wp_q, cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wp_q <= '0;
    else if (ev_load)  wp_q <= load_addr;
    else if (ev_byte)  wp_q <= row_next(wp_q);
    else if (ev_clear) wp_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ev_done) cnt_q <= wp_q;
  end

  assign wp       = wp_q;
  assign addr_cnt = cnt_q;
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int BUSY_LEN   = 128,
  parameter int PAGE_BYTES = 128,
  localparam int PAW = $clog2(PAGE_BYTES),
  localparam int CW  = $clog2(BUSY_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           scan_on,
  output logic [PAW-1:0] scan_slot
);
  localparam logic [CW-1:0] LAST = CW'(BUSY_LEN - 1);
  localparam logic [CW-1:0] SCAN = CW'(PAGE_BYTES);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign done      = busy_q && (cnt_q == LAST);
  assign scan_on   = busy_q && (cnt_q < SCAN);
  assign scan_slot = cnt_q[PAW-1:0];
endmodule

// File: rtl/pgbuf_commit_ctrl.sv
module pgbuf_commit_ctrl
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 128,
  parameter int WCYC_CYCLES = 250000,
  localparam int PAW      = $clog2(PAGE_BYTES),
  localparam int BUSY_LEN = int'(busy_len(WCYC_CYCLES, PAGE_BYTES))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              data_stb,
  input  logic [7:0]        data_in,
  input  logic              commit_req,
  input  logic              abort_req,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] addr_cnt
);
  pg_ev_e            ev;
  logic              ev_load, ev_byte, ev_commit, ev_clear, ev_done;
  logic              any_valid, scan_on, rd_valid;
  logic [PAW-1:0]    scan_slot;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] wp;

  pgbuf_evsel u_evsel (
    .busy(busy), .abort_req(abort_req), .commit_req(commit_req),
    .data_stb(data_stb), .addr_load(addr_load), .any_valid(any_valid), .ev(ev)
  );

  assign ev_load   = (ev == EV_LOAD);
  assign ev_byte   = (ev == EV_BYTE);
  assign ev_commit = (ev == EV_COMMIT);
  assign ev_clear  = (ev == EV_CLEAR);

  pgbuf_timer #(.BUSY_LEN(BUSY_LEN), .PAGE_BYTES(PAGE_BYTES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(ev_commit), .busy(busy), .done(ev_done),
    .scan_on(scan_on), .scan_slot(scan_slot)
  );

  pgbuf_stage #(.PAGE_BYTES(PAGE_BYTES)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(ev_byte), .wr_slot(wp[PAW-1:0]),
    .wr_data(data_in), .clr(ev_clear | ev_done), .rd_slot(scan_slot),
    .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
  );

  pgbuf_cursor #(.ADDR_W(ADDR_W), .PAW(PAW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .ev_load(ev_load), .ev_byte(ev_byte),
    .ev_clear(ev_clear), .ev_done(ev_done), .load_addr(load_addr),
    .wp(wp), .addr_cnt(addr_cnt)
  );

  // Cursor is frozen while busy, so its row bits name the row being written.
  assign mem_we    = scan_on && rd_valid;
  assign mem_addr  = mem_we ? {wp[ADDR_W-1:PAW], scan_slot} : '0;
  assign mem_wdata = mem_we ? rd_data : 8'h00;
endmodule

// File: rtl/pgbuf_commit_ctrl_chk.sv
module pgbuf_commit_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int PAW      = 7,
  parameter int BUSY_LEN = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_req,
  input logic              abort_req,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] addr_cnt,
  input logic              ev_done
);
  logic [31:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run) == 32'(BUSY_LEN - 1))); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < 32'(BUSY_LEN))); // R5
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_req && !abort_req)); // R10
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R12
  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:PAW] == $past(mem_addr[ADDR_W-1:PAW]))); // R2
  AST_SLOT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[PAW-1:0] > $past(mem_addr[PAW-1:0]))); // R12
  AST_CNT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_cnt) |-> ($past(ev_done) && !busy)); // R7
  AST_CNT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_cnt)); // R6
endmodule

bind pgbuf_commit_ctrl pgbuf_commit_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAW(PAW), .BUSY_LEN(BUSY_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .abort_req(abort_req),
  .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .addr_cnt(addr_cnt),
  .ev_done(ev_done)
);

// File: tb/sim_pgbuf_commit_ctrl.sv
module sim_pgbuf_commit_ctrl;
  localparam int P_AW   = 16;
  localparam int P_PAGE = 16;
  localparam int P_WCYC = 40;
  localparam int P_BUSY = (P_WCYC > P_PAGE) ? P_WCYC : P_PAGE;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            addr_load = 1'b0;
  logic [P_AW-1:0] load_addr = '0;
  logic            data_stb = 1'b0;
  logic [7:0]      data_in = '0;
  logic            commit_req = 1'b0;
  logic            abort_req = 1'b0;
  logic            busy, mem_we;
  logic [P_AW-1:0] mem_addr, addr_cnt;
  logic [7:0]      mem_wdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pgbuf_commit_ctrl #(.ADDR_W(P_AW), .PAGE_BYTES(P_PAGE), .WCYC_CYCLES(P_WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr),
    .data_stb(data_stb), .data_in(data_in), .commit_req(commit_req),
    .abort_req(abort_req), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .addr_cnt(addr_cnt)
  );

  // Behavioural reference
  byte unsigned m_buf [P_PAGE];
  bit           m_val [P_PAGE];
  int           m_wp, m_cnt, m_t;
  bit           m_busy;
  byte unsigned dut_mem [int];

  function automatic bit m_any();
    foreach (m_val[i]) if (m_val[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wp = 0; m_cnt = 0; m_t = 0; m_busy = 0;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (m_busy) begin
      if (m_t == P_BUSY - 1) begin
        m_busy = 0; m_cnt = m_wp;
        foreach (m_val[i]) m_val[i] = 0;
      end else m_t++;
    end else if (abort_req || (commit_req && !m_any())) begin
      foreach (m_val[i]) m_val[i] = 0;
      m_wp = m_cnt;
    end else if (commit_req) begin
      m_busy = 1; m_t = 0;
    end else if (data_stb) begin
      int s;
      s = m_wp % P_PAGE;
      m_buf[s] = data_in; m_val[s] = 1;
      m_wp = (m_wp / P_PAGE) * P_PAGE + (s + 1) % P_PAGE;
    end else if (addr_load) m_wp = int'(load_addr);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_we;
      int e_addr;
      e_we = m_busy && (m_t < P_PAGE) && m_val[m_t];
      e_addr = (m_wp / P_PAGE) * P_PAGE + m_t;
      chk(busy == m_busy, "R5 busy per cycle", busy, m_busy);
      chk(int'(addr_cnt) == m_cnt, "R7 addr_cnt per cycle", addr_cnt, m_cnt);
      chk(mem_we == e_we, "R12 mem_we per cycle", mem_we, e_we);
      if (e_we) begin
        chk(int'(mem_addr) == e_addr, "R2 mem_addr per cycle", mem_addr, e_addr);
        chk(mem_wdata == m_buf[m_t], "R4 mem_wdata per cycle", mem_wdata, m_buf[m_t]);
      end
      if (mem_we) dut_mem[int'(mem_addr)] = mem_wdata;
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  task automatic pulse(input bit ld, input int a, input bit ds, input int d,
                       input bit cm, input bit ab);
    addr_load = ld; load_addr = P_AW'(a); data_stb = ds; data_in = 8'(d);
    commit_req = cm; abort_req = ab;
    @(negedge clk);
    addr_load = 0; data_stb = 0; commit_req = 0; abort_req = 0;
  endtask

  task automatic load(input int a);  pulse(1, a, 0, 0, 0, 0); endtask
  task automatic put(input int d);   pulse(0, 0, 1, d, 0, 0); endtask
  task automatic commit();           pulse(0, 0, 0, 0, 1, 0); endtask
  task automatic abort_t();          pulse(0, 0, 0, 0, 0, 1); endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic mem_is(input int a, input int v, input string tag);
    chk(dut_mem.exists(a) && dut_mem[a] == v, tag, dut_mem.exists(a) ? dut_mem[a] : -1, v);
  endtask

  task automatic mem_none(input int a, input string tag);
    chk(!dut_mem.exists(a), tag, a, -1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_we && addr_cnt == 0, "R1 during reset", {busy, mem_we, addr_cnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_we && addr_cnt == 0, "R1 after reset", {busy, mem_we, addr_cnt}, 0);

    // R2 R5 R7: plain three-byte page write
    load(16'h1234); put(8'h11); put(8'h22); put(8'h33); commit();
    wait_idle(n);
    chk(n == P_BUSY, "R5 busy length", n, P_BUSY);
    mem_is(16'h1234, 8'h11, "R2 byte0"); mem_is(16'h1236, 8'h33, "R2 byte2");
    mem_none(16'h1237, "R2 unstaged slot");
    chk(addr_cnt == 16'h1237, "R7 next address", addr_cnt, 16'h1237);

    // R3: wrap inside the row
    load(16'h20FE); put(8'hA1); put(8'hA2); put(8'hA3); put(8'hA4); commit();
    wait_idle(n);
    mem_is(16'h20FF, 8'hA2, "R3 row end"); mem_is(16'h20F0, 8'hA3, "R3 wrapped slot0");
    mem_none(16'h2100, "R3 next row untouched");
    chk(addr_cnt == 16'h20F2, "R3 R7 wrapped counter", addr_cnt, 16'h20F2);

    // R4: 17 bytes into a 16-byte row
    load(16'h3000);
    for (int i = 0; i < 17; i++) put(8'h40 + i);
    commit(); wait_idle(n);
    mem_is(16'h3000, 8'h50, "R4 later byte wins"); mem_is(16'h300F, 8'h4F, "R4 last slot");
    chk(addr_cnt == 16'h3001, "R4 counter", addr_cnt, 16'h3001);

    // R8 R9: abort, then empty commit
    load(16'h4000); put(8'h77); put(8'h78); abort_t();
    chk(addr_cnt == 16'h3001, "R8 counter kept", addr_cnt, 16'h3001);
    commit();
    chk(!busy, "R9 empty commit no busy", busy, 0);
    repeat (2) @(negedge clk);
    mem_none(16'h4000, "R8 aborted byte not written");

    // R6: requests during busy
    load(16'h5000); put(8'h91); commit();
    load(16'h6000); put(8'h92); abort_t(); commit();
    wait_idle(n);
    mem_is(16'h5000, 8'h91, "R6 committed byte");
    mem_none(16'h5001, "R6 byte during busy"); mem_none(16'h6000, "R6 load during busy");
    chk(addr_cnt == 16'h5001, "R6 counter", addr_cnt, 16'h5001);
    commit();
    chk(!busy, "R6 no leftover staging", busy, 0);

    // R10: precedence
    load(16'h7000); put(8'hA5);
    pulse(0, 0, 1, 8'hEE, 1, 1);
    chk(!busy && addr_cnt == 16'h5001, "R10 abort over commit", {busy, addr_cnt}, 16'h5001);
    load(16'h7100); put(8'hB1);
    pulse(0, 0, 1, 8'hB2, 1, 0);
    chk(busy, "R10 commit over byte", busy, 1);
    wait_idle(n);
    mem_is(16'h7100, 8'hB1, "R10 staged byte"); mem_none(16'h7101, "R10 byte dropped");
    mem_none(16'h7000, "R10 aborted row");
    pulse(1, 16'h7800, 1, 8'hC1, 0, 0); commit(); wait_idle(n);
    mem_is(16'h7101, 8'hC1, "R10 byte over load"); mem_none(16'h7800, "R10 load dropped");
    chk(addr_cnt == 16'h7102, "R10 counter", addr_cnt, 16'h7102);

    // R11: no load in the transaction
    put(8'hD1); commit(); wait_idle(n);
    mem_is(16'h7102, 8'hD1, "R11 starts at counter");
    chk(addr_cnt == 16'h7103, "R11 counter", addr_cnt, 16'h7103);

    report();
  end
endmodule